// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block steers the gain code of a recording-path programmable amplifier so that the digitised audio level settles near a programmed target. Every valid stereo sample pair from the converter is reduced to a peak magnitude and compared against the target. Samples above the target pull the gain down one code at a time at the attack pace. After a run of quiet samples, the gain climbs back one code at a time at the release pace. The gain code runs from 0 (-14 dB) to 96 (+34 dB) in 0.5 dB steps, and code 28 is 0 dB.

The same engine acts as a limiter when limiter mode lowers its ceiling to 0 dB, so it can only cut gain. With automatic control off, the code follows a manual register field. An optional zero-crossing mode holds a pending code change until the left channel changes sign, with a sample-count timeout that forces the change. Each channel has a mute output that follows its own mute control, whatever the gain state.

Top module: `alc_gain_engine`

## Requirements
- R1: While rstN is low, and on the first clock after it, gainCode is 28, both mute outputs are 0 and the internal step, hold and timeout counters are cleared.
- R2: In automatic mode, a valid sample whose peak magnitude max(|sampleL|,|sampleR|) is strictly above targetLevel lowers the desired code by one, provided at least attackInt valid samples have passed since the last step (the step counter is at least attackInt). Otherwise the code holds.
- R3: In automatic mode, a valid sample at or below the target raises the desired code by one only when at least recoveryWait consecutive non-overshoot samples came before it and the step counter is at least releaseInt.
- R4: In automatic mode the code saturates, without wrapping, in the range 0 to min(maxGain, 96). It changes only on cycles that follow a valid sample.
- R5: With limiterMode set, the ceiling becomes min(maxGain, 28). The first valid sample after limiter mode is set clamps the desired code to that ceiling.
- R6: With alcEnable low, gainCode equals min(manualGain, 96) from the clock after it is set, and samples have no effect on it. Automatic control resumes from that code.
- R7: With zeroCrossEn set, the output code takes the desired value only on a valid sample whose sampleL sign bit differs from the previous sample's sign bit, or once a change has been pending for zcTimeout samples without being applied.
- R8: With zeroCrossEn clear, a new desired code appears on gainCode on the clock right after the sample that caused it.
- R9: muteOutL and muteOutR equal muteL and muteR delayed by one clock, and muting does not change gainCode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | Sample pair is valid this cycle |
| sampleL | input | 16 | Left channel sample, two's complement |
| sampleR | input | 16 | Right channel sample, two's complement |
| alcEnable | input | 1 | 1 = automatic control, 0 = manual code |
| limiterMode | input | 1 | Caps the ceiling at the 0 dB code |
| zeroCrossEn | input | 1 | Apply code changes at sign changes only |
| targetLevel | input | 15 | Peak magnitude target |
| maxGain | input | 7 | Upper code bound in automatic mode |
| manualGain | input | 7 | Code used when automatic control is off |
| attackInt | input | 8 | Minimum samples between downward steps |
| releaseInt | input | 8 | Minimum samples between upward steps |
| recoveryWait | input | 8 | Quiet samples required before release starts |
| zcTimeout | input | 8 | Pending samples before a forced change |
| muteL | input | 1 | Left mute control |
| muteR | input | 1 | Right mute control |
| gainCode | output | 7 | Amplifier gain code, 0 = -14 dB, 96 = +34 dB |
| muteOutL | output | 1 | Left mute output |
| muteOutR | output | 1 | Right mute output |

## Verification
The bench builds the engine with its default parameters: 16-bit samples, a 7-bit code with 97 codes and unity at 28, and 8-bit timers. It programs short attack, release and recovery intervals (2, 3 and 4 samples), so a few hundred samples sweep the code through its whole range. That covers saturation at code 0, at code 96, at a lowered maxGain and at the limiter ceiling. A timeout of 5 lets a run of samples without a sign change force the zero-crossing path, and an alternating-sign run exercises the normal crossing.

// File: rtl/alc_gain_pkg.sv
package alc_gain_pkg;
  // Strobes from the control side to the gain datapath, valid for one cycle.
  typedef struct packed {
    logic loadManual;  // automatic control off: load manual code
    logic stepDown;    // lower desired code by one
    logic stepUp;      // raise desired code by one
    logic applyNow;    // copy desired code to the output code
  } alcStrobe_t;
endpackage

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_gain_pkg::*;
#(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               alcEnable,
  input  logic               zeroCrossEn,
  input  logic               overshoot,
  input  logic               signFlip,
  input  logic               changePending,
  input  logic [TIMER_W-1:0] attackInt,
  input  logic [TIMER_W-1:0] releaseInt,
  input  logic [TIMER_W-1:0] recoveryWait,
  input  logic [TIMER_W-1:0] zcTimeout,
  output alcStrobe_t         strobe
);
  localparam logic [TIMER_W-1:0] CNT_MAX = '1;

  logic [TIMER_W-1:0] stepCnt, holdCnt, zcCnt;

  function automatic logic [TIMER_W-1:0] satInc(input logic [TIMER_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    strobe = '0;
    strobe.loadManual = !alcEnable;
    if (alcEnable && sampleValid) begin
      strobe.stepDown = overshoot && (stepCnt >= attackInt);
      strobe.stepUp   = !overshoot && (holdCnt >= recoveryWait) && (stepCnt >= releaseInt);
      strobe.applyNow = !zeroCrossEn || signFlip || (changePending && (zcCnt >= zcTimeout));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !alcEnable) begin
      stepCnt <= '0;
      holdCnt <= '0;
      zcCnt   <= '0;
    end else if (sampleValid) begin
      stepCnt <= (strobe.stepDown || strobe.stepUp) ? '0 : satInc(stepCnt);
      holdCnt <= overshoot ? '0 : satInc(holdCnt);
      zcCnt   <= (changePending && !strobe.applyNow) ? satInc(zcCnt) : '0;
    end
  end
endmodule

// File: rtl/alc_gain_datapath.sv
module alc_gain_datapath
  import alc_gain_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int GAIN_W     = 7,
  parameter int NUM_CODES  = 97,
  parameter int UNITY_CODE = 28
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleL,
  input  logic signed [SAMPLE_W-1:0] sampleR,
  input  logic [SAMPLE_W-2:0]        targetLevel,
  input  logic                       limiterMode,
  input  logic [GAIN_W-1:0]          maxGain,
  input  logic [GAIN_W-1:0]          manualGain,
  input  logic                       muteL,
  input  logic                       muteR,
  input  alcStrobe_t                 strobe,
  output logic                       overshoot,
  output logic                       signFlip,
  output logic                       changePending,
  output logic [GAIN_W-1:0]          gainCode,
  output logic                       muteOutL,
  output logic                       muteOutR
);
  localparam int NUM_CH = 2;
  localparam logic [GAIN_W-1:0] MAX_CODE = GAIN_W'(NUM_CODES - 1);
  localparam logic [GAIN_W-1:0] UNITY    = GAIN_W'(UNITY_CODE);

  logic signed [SAMPLE_W-1:0] chanIn  [NUM_CH];
  logic [SAMPLE_W-1:0]        chanMag [NUM_CH];
  logic [NUM_CH-1:0]          muteIn, muteReg;

  assign chanIn[0] = sampleL;
  assign chanIn[1] = sampleR;
  assign muteIn    = {muteR, muteL};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    assign chanMag[ch] = chanIn[ch][SAMPLE_W-1] ? $unsigned(-chanIn[ch]) : $unsigned(chanIn[ch]);
    always_ff @(posedge clk) begin
      if (!rstN) muteReg[ch] <= 1'b0;
      else       muteReg[ch] <= muteIn[ch];
    end
  end

  logic [SAMPLE_W-1:0] peakMag;
  logic                prevSign;
  logic [GAIN_W-1:0]   desiredCode, appliedCode;
  logic [GAIN_W-1:0]   modeCeil, ceilCode, steppedCode, nextDesired, manualCode;

  assign peakMag       = (chanMag[0] > chanMag[1]) ? chanMag[0] : chanMag[1];
  assign overshoot     = sampleValid && (peakMag > {1'b0, targetLevel});
  assign signFlip      = sampleValid && (sampleL[SAMPLE_W-1] != prevSign);
  assign changePending = (desiredCode != appliedCode);

  always_comb begin
    modeCeil   = limiterMode ? UNITY : MAX_CODE;
    ceilCode   = (maxGain < modeCeil) ? maxGain : modeCeil;
    manualCode = (manualGain > MAX_CODE) ? MAX_CODE : manualGain;
    steppedCode = desiredCode;
    if (strobe.stepDown) begin
      if (desiredCode != '0) steppedCode = desiredCode - 1'b1;
    end else if (strobe.stepUp) begin
      steppedCode = desiredCode + 1'b1;
    end
    nextDesired = (steppedCode > ceilCode) ? ceilCode : steppedCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      desiredCode <= UNITY;
      appliedCode <= UNITY;
      prevSign    <= 1'b0;
    end else begin
      if (strobe.loadManual) begin
        desiredCode <= manualCode;
        appliedCode <= manualCode;
      end else if (sampleValid) begin
        desiredCode <= nextDesired;
        if (strobe.applyNow) appliedCode <= nextDesired;
      end
      if (sampleValid) prevSign <= sampleL[SAMPLE_W-1];
    end
  end

  assign gainCode = appliedCode;
  assign muteOutL = muteReg[0];
  assign muteOutR = muteReg[1];
endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
  import alc_gain_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int GAIN_W     = 7,
  parameter int NUM_CODES  = 97,
  parameter int UNITY_CODE = 28,
  parameter int TIMER_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleL,
  input  logic signed [SAMPLE_W-1:0] sampleR,
  input  logic                       alcEnable,
  input  logic                       limiterMode,
  input  logic                       zeroCrossEn,
  input  logic [SAMPLE_W-2:0]        targetLevel,
  input  logic [GAIN_W-1:0]          maxGain,
  input  logic [GAIN_W-1:0]          manualGain,
  input  logic [TIMER_W-1:0]         attackInt,
  input  logic [TIMER_W-1:0]         releaseInt,
  input  logic [TIMER_W-1:0]         recoveryWait,
  input  logic [TIMER_W-1:0]         zcTimeout,
  input  logic                       muteL,
  input  logic                       muteR,
  output logic [GAIN_W-1:0]          gainCode,
  output logic                       muteOutL,
  output logic                       muteOutR
);
  alcStrobe_t strobe;
  logic overshoot, signFlip, changePending;

  alc_gain_ctrl #(.TIMER_W(TIMER_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .alcEnable(alcEnable), .zeroCrossEn(zeroCrossEn),
    .overshoot(overshoot), .signFlip(signFlip), .changePending(changePending),
    .attackInt(attackInt), .releaseInt(releaseInt),
    .recoveryWait(recoveryWait), .zcTimeout(zcTimeout),
    .strobe(strobe)
  );

  alc_gain_datapath #(
    .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W),
    .NUM_CODES(NUM_CODES), .UNITY_CODE(UNITY_CODE)
  ) uData (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleL(sampleL), .sampleR(sampleR), .targetLevel(targetLevel),
    .limiterMode(limiterMode), .maxGain(maxGain), .manualGain(manualGain),
    .muteL(muteL), .muteR(muteR), .strobe(strobe),
    .overshoot(overshoot), .signFlip(signFlip), .changePending(changePending),
    .gainCode(gainCode), .muteOutL(muteOutL), .muteOutR(muteOutR)
  );
endmodule

// File: rtl/alc_gain_checker.sv
module alc_gain_checker #(
  parameter int GAIN_W     = 7,
  parameter int NUM_CODES  = 97,
  parameter int UNITY_CODE = 28
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              alcEnable,
  input logic              limiterMode,
  input logic              zeroCrossEn,
  input logic [GAIN_W-1:0] manualGain,
  input logic              muteL,
  input logic              muteR,
  input logic [GAIN_W-1:0] gainCode,
  input logic              muteOutL,
  input logic              muteOutR
);
  localparam logic [GAIN_W-1:0] MAX_CODE = GAIN_W'(NUM_CODES - 1);
  localparam logic [GAIN_W-1:0] UNITY    = GAIN_W'(UNITY_CODE);

  // R4: code never leaves the legal range
  assert_code_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    gainCode <= MAX_CODE);

  // R4: automatic mode only moves the code after a valid sample
  assert_hold_between_samples_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(alcEnable) && !$past(sampleValid)) |-> $stable(gainCode));

  // R5: limiter ceiling holds right after a sample in immediate-apply mode
  assert_limiter_ceiling_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(alcEnable) && $past(limiterMode) && $past(sampleValid)
     && !$past(zeroCrossEn)) |-> (gainCode <= UNITY));

  // R6: manual mode follows the clamped manual field
  assert_manual_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(alcEnable)) |->
      (gainCode == (($past(manualGain) > MAX_CODE) ? MAX_CODE : $past(manualGain))));

  // R9: mute outputs track the mute controls one clock later
  assert_mute_track_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (muteOutL == $past(muteL) && muteOutR == $past(muteR)));
endmodule

bind alc_gain_engine alc_gain_checker #(
  .GAIN_W(GAIN_W), .NUM_CODES(NUM_CODES), .UNITY_CODE(UNITY_CODE)
) uChk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .alcEnable(alcEnable),
  .limiterMode(limiterMode), .zeroCrossEn(zeroCrossEn), .manualGain(manualGain),
  .muteL(muteL), .muteR(muteR), .gainCode(gainCode),
  .muteOutL(muteOutL), .muteOutR(muteOutR)
);

// File: tb/sim_alc_gain_engine.sv
module sim_alc_gain_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleL = '0, sampleR = '0;
  logic alcEnable = 1'b1, limiterMode = 1'b0, zeroCrossEn = 1'b0;
  logic [14:0] targetLevel = 15'd8000;
  logic [6:0] maxGain = 7'd96, manualGain = 7'd0;
  logic [7:0] attackInt = 8'd2, releaseInt = 8'd3, recoveryWait = 8'd4, zcTimeout = 8'd5;
  logic muteL = 1'b0, muteR = 1'b0;
  logic [6:0] gainCode;
  logic muteOutL, muteOutR;

  always #4 clk = ~clk;

  alc_gain_engine u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleL(sampleL), .sampleR(sampleR), .alcEnable(alcEnable),
    .limiterMode(limiterMode), .zeroCrossEn(zeroCrossEn),
    .targetLevel(targetLevel), .maxGain(maxGain), .manualGain(manualGain),
    .attackInt(attackInt), .releaseInt(releaseInt),
    .recoveryWait(recoveryWait), .zcTimeout(zcTimeout),
    .muteL(muteL), .muteR(muteR),
    .gainCode(gainCode), .muteOutL(muteOutL), .muteOutR(muteOutR)
  );

  int tests = 0, fails = 0;
  int expQ[$];
  string tagQ[$];
  bit done = 0;

  // reference model state
  int mDes = 28, mApp = 28, mStep = 0, mHold = 0, mZc = 0;
  bit mPrev = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    return (v >= 255) ? 255 : v + 1;
  endfunction

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // driver side: compute expected code from the requirements and queue it
  task automatic modelSample(input int l, input int r);
    int peak, ceilC, nd, manC;
    bit over, flip, down, up, pend, apply;
    manC = (int'(manualGain) > 96) ? 96 : int'(manualGain);
    if (!alcEnable) begin
      mDes = manC; mApp = manC; mStep = 0; mHold = 0; mZc = 0;
      expQ.push_back(mApp); tagQ.push_back("R6");
    end else begin
      peak  = (absv(l) > absv(r)) ? absv(l) : absv(r);
      over  = peak > int'(targetLevel);
      flip  = (l < 0) != mPrev;
      down  = over && (mStep >= int'(attackInt));
      up    = !over && (mHold >= int'(recoveryWait)) && (mStep >= int'(releaseInt));
      pend  = (mDes != mApp);
      apply = !zeroCrossEn || flip || (pend && mZc >= int'(zcTimeout));
      ceilC = limiterMode ? 28 : 96;
      if (int'(maxGain) < ceilC) ceilC = int'(maxGain);
      nd = mDes;
      if (down) begin
        if (nd > 0) nd--;
      end else if (up) nd++;
      if (nd > ceilC) nd = ceilC;
      mStep = (down || up) ? 0 : sat8(mStep);
      mHold = over ? 0 : sat8(mHold);
      mZc   = (pend && !apply) ? sat8(mZc) : 0;
      mDes  = nd;
      if (apply) mApp = nd;
      expQ.push_back(mApp);
      tagQ.push_back(zeroCrossEn ? "R7" : "R8");
    end
    mPrev = (l < 0);
  endtask

  task automatic sendSample(input int l, input int r);
    @(negedge clk);
    sampleL = 16'(l); sampleR = 16'(r); sampleValid = 1'b1;
    modelSample(l, r);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // monitor: pops one expected code per accepted sample
  initial begin
    forever begin
      @(posedge clk);
      if (sampleValid === 1'b1) begin
        int e; string t;
        @(negedge clk);
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, int'(gainCode), e);
      end
    end
  end

  task automatic syncManual();
    @(negedge clk);
    @(negedge clk);
    if (!alcEnable) begin
      mDes = (int'(manualGain) > 96) ? 96 : int'(manualGain);
      mApp = mDes; mStep = 0; mHold = 0; mZc = 0;
    end
  endtask

  function automatic int tri16(input int i, input int amp);
    int k, v;
    k = i % 16;
    v = (k < 8) ? k : 16 - k;
    return amp * (v - 4) / 4;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    bit mono;
    int prev;
    repeat (4) @(negedge clk);
    check("R1 gain in reset", int'(gainCode), 28);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 gain after reset", int'(gainCode), 28);
    check("R1 muteL after reset", int'(muteOutL), 0);
    check("R1 muteR after reset", int'(muteOutR), 0);

    // R2: attack interval from cleared timers
    sendSample(20000, 100);
    sendSample(100, -20000);
    check("R2 no step before interval", int'(gainCode), 28);
    sendSample(20000, 0);
    check("R2 first attack step", int'(gainCode), 27);

    // R2: loud triangle burst, gain must never rise
    mono = 1; prev = int'(gainCode);
    for (int i = 0; i < 60; i++) begin
      sendSample(tri16(i, 24000), tri16(i + 3, 24000));
      if (int'(gainCode) > prev) mono = 0;
      prev = int'(gainCode);
    end
    check("R2 monotone decrease", int'(mono), 1);
    check("R2 below unity", int'(gainCode < 7'd27), 1);

    // R4: sustained overload saturates at code 0
    for (int i = 0; i < 120; i++) sendSample(30000, -30000);
    check("R4 floor code", int'(gainCode), 0);

    // R3: recovery wait then release
    for (int i = 0; i < 4; i++) sendSample(tri16(i, 800), 0);
    check("R3 held during recovery", int'(gainCode), 0);
    sendSample(tri16(4, 800), 0);
    check("R3 first release step", int'(gainCode), 1);
    mono = 1; prev = int'(gainCode);
    for (int i = 0; i < 450; i++) begin
      sendSample(tri16(i, 800), tri16(i, 600));
      if (int'(gainCode) < prev) mono = 0;
      prev = int'(gainCode);
    end
    check("R3 monotone recovery", int'(mono), 1);
    check("R4 ceiling code", int'(gainCode), 96);

    // R5: limiter ceiling
    @(negedge clk); limiterMode = 1'b1;
    sendSample(500, 500);
    check("R5 limiter clamp", int'(gainCode), 28);
    for (int i = 0; i < 20; i++) sendSample(tri16(i, 500), 0);
    check("R5 limiter stays", int'(gainCode), 28);

    // R4: lowered maxGain ceiling
    @(negedge clk); limiterMode = 1'b0; maxGain = 7'd40;
    for (int i = 0; i < 80; i++) sendSample(tri16(i, 500), 0);
    check("R4 maxGain ceiling", int'(gainCode), 40);

    // R7: zero-cross with timeout, then alternating signs
    @(negedge clk); maxGain = 7'd96; zeroCrossEn = 1'b1;
    for (int i = 0; i < 20; i++) sendSample(30000, 30000);
    check("R7 timeout forced change", int'(gainCode < 7'd40), 1);
    for (int i = 0; i < 20; i++) sendSample((i % 2) ? -30000 : 30000, 0);
    @(negedge clk); zeroCrossEn = 1'b0;
    sendSample(30000, 0);

    // R6: manual override
    @(negedge clk); alcEnable = 1'b0; manualGain = 7'd70;
    syncManual();
    check("R6 manual code", int'(gainCode), 70);
    for (int i = 0; i < 5; i++) sendSample(30000, -30000);
    check("R6 samples ignored", int'(gainCode), 70);
    @(negedge clk); manualGain = 7'd120;
    syncManual();
    check("R6 manual clamp", int'(gainCode), 96);

    // R9: mutes
    @(negedge clk); muteL = 1'b1;
    @(negedge clk);
    check("R9 muteL set", int'(muteOutL), 1);
    check("R9 muteR clear", int'(muteOutR), 0);
    check("R9 gain unaffected", int'(gainCode), 96);
    muteR = 1'b1; muteL = 1'b0;
    @(negedge clk);
    check("R9 muteR set", int'(muteOutR), 1);
    check("R9 muteL clear", int'(muteOutL), 0);
    muteR = 1'b0;

    // R8: back to automatic, immediate apply
    @(negedge clk); alcEnable = 1'b1;
    syncManual();
    for (int i = 0; i < 3; i++) sendSample(-30000, 0);
    check("R8 immediate step", int'(gainCode), 95);

    repeat (4) @(negedge clk);
    check("R8 queue drained", expQ.size(), 0);
    finishRun();
  end
endmodule